// File: doc/BRIEF.md
# Component Video Output Level Multiplexer

This block sits between a three-channel digital video bus and three 11-bit DAC code outputs. An internal raster position (pixel within the line, line within an interlaced frame) is held in step with the incoming samples. Each line is classified from this position as an active picture line, a vertical blanking line or a vertical sync line. For every sample the block then chooses one of two sources: the input pixel, or one of three programmable level codes (blank, sync-low and sync-high). Channel 0 carries luma or green. Channels 1 and 2 carry the chroma pair, or blue and red.

A pass-through switch lets input data through inside the active pixel window on vertical blanking lines. This is useful for carrying ancillary data. A PC-graphics switch forwards the input bus on every sample with no substitution. A colour-space switch selects where the headroom offset goes: on all three channels in RGB output, or on luma alone in YPbPr output. Level codes are captured once per frame, so they cannot change the picture partway through.

Top module: `vid_level_mux`

## Requirements
- R1: Each output sample depends on the inputs and raster position of the previous clock only, in every mode. While reset is high, all DAC outputs and the field flag read 0, and the raster returns to line 1, pixel 0.
- R2: Pixels count from 0 to line_len-1. Lines count from 1 to frame_lines and then wrap to 1. The field flag, delayed by one cycle like the data, is 1 on lines numbered above field_lines.
- R3: Outside PC-graphics mode, pixels 0 to sync_w-1 of every line carry the sync-low codes. Pixels sync_w to 2*sync_w-1 carry the sync-high codes.
- R4: On an active line, pixels in the window act_start <= pixel < act_end forward the input. Field 1 active lines run from f1_first to f1_last, and field 2 active lines run from f2_first to f2_last (absolute line numbers).
- R5: On a vertical blanking line, the active window carries the blank codes. When pass-through is 1, it forwards the input instead.
- R6: On a vertical sync line, every pixel after the sync header carries the sync-low codes, and pass-through has no effect. Vertical sync lines are lines 1 to vs_lines of field 1 and lines field_lines+1 to field_lines+vs_lines of field 2.
- R7: On non-sync lines, pixels outside both the sync header and the active window carry the blank codes.
- R8: In PC-graphics mode, each output is the input sample of the previous cycle, plus the offset of R10.
- R9: Channel 0 uses the luma level set. Channels 1 and 2 share the chroma level set.
- R10: The HEADROOM offset (default 300) is added to channel 0 always, and to channels 1 and 2 only in RGB mode. Sums above 2047 saturate to 2047.
- R11: Level codes are captured during reset and on the last pixel of the frame. A change at any other time first shows on line 1, pixel 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pc_mode | input | 1 | 1: forward input on every sample |
| cfg_rgb | input | 1 | 1: offset on all channels; 0: luma only |
| cfg_passthru | input | 1 | 1: forward input in window on blanking lines |
| cfg_line_len | input | PIX_W | Samples per line |
| cfg_sync_w | input | PIX_W | Width of each sync header phase |
| cfg_act_start | input | PIX_W | First pixel of active window |
| cfg_act_end | input | PIX_W | Pixel after the active window |
| cfg_frame_lines | input | LINE_W | Lines per frame |
| cfg_field_lines | input | LINE_W | Lines in field 1 |
| cfg_vs_lines | input | LINE_W | Vertical sync lines at start of each field |
| cfg_f1_first | input | LINE_W | First active line, field 1 |
| cfg_f1_last | input | LINE_W | Last active line, field 1 |
| cfg_f2_first | input | LINE_W | First active line, field 2 |
| cfg_f2_last | input | LINE_W | Last active line, field 2 |
| cfg_y_blank | input | 11 | Luma blank code |
| cfg_y_sync_lo | input | 11 | Luma sync-low code |
| cfg_y_sync_hi | input | 11 | Luma sync-high code |
| cfg_c_blank | input | 11 | Chroma blank code |
| cfg_c_sync_lo | input | 11 | Chroma sync-low code |
| cfg_c_sync_hi | input | 11 | Chroma sync-high code |
| vid_y | input | 11 | Input channel 0 |
| vid_cb | input | 11 | Input channel 1 |
| vid_cr | input | 11 | Input channel 2 |
| dac_y | output | 11 | DAC code, channel 0 |
| dac_cb | output | 11 | DAC code, channel 1 |
| dac_cr | output | 11 | DAC code, channel 2 |
| dac_field | output | 1 | Field flag aligned with DAC codes |

## Verification
The assertions assume that the timing inputs are static while out of reset. They also assume a consistent geometry: line_len of at least 2, 2*sync_w below line_len, and field_lines below frame_lines. Under those assumptions the raster range and wrap properties hold. The stimulus programs the timing once, before reset is released, and afterwards changes only the level codes, mode bits and pixel data. The level codes are sometimes changed in the middle of a frame, which exercises the capture window.

// File: rtl/vlm_pkg.sv
package vlm_pkg;

    localparam int unsigned CODE_W = 11;
    localparam int unsigned NUM_CH = 3;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [NUM_CH-1:0][CODE_W-1:0] trio_t;

    typedef enum logic [1:0] {
        LK_ACTIVE = 2'd0,
        LK_BLANK  = 2'd1,
        LK_VSYNC  = 2'd2
    } line_kind_e;

    typedef enum logic [1:0] {
        SRC_VIDEO   = 2'd0,
        SRC_BLANK   = 2'd1,
        SRC_SYNC_LO = 2'd2,
        SRC_SYNC_HI = 2'd3
    } src_e;

    typedef struct packed {
        code_t blank;
        code_t sync_lo;
        code_t sync_hi;
    } lvl_set_t;

    typedef struct packed {
        line_kind_e kind;
        logic       in_win;
        logic       hdr_lo;
        logic       hdr_hi;
        logic       field2;
        logic       frame_end;
    } rast_t;

    function automatic code_t sat_add(code_t a, code_t b);
        logic [CODE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CODE_W] ? {CODE_W{1'b1}} : s[CODE_W-1:0];
    endfunction

    // Header phases win over line type; PC mode wins over all.
    function automatic src_e pick_src(logic pc_mode, logic passthru, rast_t r);
        if (pc_mode)                    return SRC_VIDEO;
        else if (r.hdr_lo)              return SRC_SYNC_LO;
        else if (r.hdr_hi)              return SRC_SYNC_HI;
        else if (r.kind == LK_VSYNC)    return SRC_SYNC_LO;
        else if (r.in_win && (r.kind == LK_ACTIVE || passthru))
                                        return SRC_VIDEO;
        else                            return SRC_BLANK;
    endfunction

endpackage

// File: rtl/vlm_raster.sv
module vlm_raster
    import vlm_pkg::*;
#(
    parameter int unsigned PIX_W  = 12,
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  cfg_line_len,
    input  logic [PIX_W-1:0]  cfg_sync_w,
    input  logic [PIX_W-1:0]  cfg_act_start,
    input  logic [PIX_W-1:0]  cfg_act_end,
    input  logic [LINE_W-1:0] cfg_frame_lines,
    input  logic [LINE_W-1:0] cfg_field_lines,
    input  logic [LINE_W-1:0] cfg_vs_lines,
    input  logic [LINE_W-1:0] cfg_f1_first,
    input  logic [LINE_W-1:0] cfg_f1_last,
    input  logic [LINE_W-1:0] cfg_f2_first,
    input  logic [LINE_W-1:0] cfg_f2_last,
    output rast_t             rast_o
);

    localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);
    localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

    logic [PIX_W-1:0]  pix_q;
    logic [LINE_W-1:0] line_q;
    logic              last_pix;
    logic              last_line;
    logic              field2;
    logic [LINE_W-1:0] vs_end;
    logic              is_vs;
    logic              is_act;
    logic [PIX_W:0]    sync_w2;
    line_kind_e        kind;

    assign last_pix  = (pix_q == (cfg_line_len - PIX_ONE));
    assign last_line = (line_q == cfg_frame_lines);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q  <= '0;
            line_q <= LINE_ONE;
        end else if (last_pix) begin
            pix_q  <= '0;
            line_q <= last_line ? LINE_ONE : (line_q + LINE_ONE);
        end else begin
            pix_q  <= pix_q + PIX_ONE;
        end
    end

    always_comb begin
        field2  = (line_q > cfg_field_lines);
        vs_end  = field2 ? (cfg_field_lines + cfg_vs_lines) : cfg_vs_lines;
        is_vs   = (line_q <= vs_end);
        is_act  = field2 ? ((line_q >= cfg_f2_first) && (line_q <= cfg_f2_last))
                         : ((line_q >= cfg_f1_first) && (line_q <= cfg_f1_last));
        if (is_vs)       kind = LK_VSYNC;
        else if (is_act) kind = LK_ACTIVE;
        else             kind = LK_BLANK;
        sync_w2 = {cfg_sync_w, 1'b0};
    end

    always_comb begin
        rast_o.kind      = kind;
        rast_o.field2    = field2;
        rast_o.hdr_lo    = (pix_q < cfg_sync_w);
        rast_o.hdr_hi    = !(pix_q < cfg_sync_w) && ({1'b0, pix_q} < sync_w2);
        rast_o.in_win    = (pix_q >= cfg_act_start) && (pix_q < cfg_act_end);
        rast_o.frame_end = last_pix && last_line;
    end

    // R2
    line_range_chk: assert property (@(posedge clk) disable iff (rst)
        (line_q >= LINE_ONE) && (line_q <= cfg_frame_lines));

    // R2
    pix_step_chk: assert property (@(posedge clk) disable iff (rst)
        !last_pix |=> (pix_q == $past(pix_q) + PIX_ONE) && $stable(line_q));

    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        rast_o.frame_end |=> (line_q == LINE_ONE) && (pix_q == '0));

endmodule

// File: rtl/vlm_level_sel.sv
module vlm_level_sel
    import vlm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_end_i,
    input  lvl_set_t cfg_luma,
    input  lvl_set_t cfg_chroma,
    input  src_e     src_i,
    input  trio_t    vid_i,
    output trio_t    sel_o
);

    lvl_set_t luma_q;
    lvl_set_t chroma_q;

    always_ff @(posedge clk) begin
        if (rst || frame_end_i) begin
            luma_q   <= cfg_luma;
            chroma_q <= cfg_chroma;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        lvl_set_t set;
        if (ch == 0) begin : g_luma
            assign set = luma_q;
        end else begin : g_chroma
            assign set = chroma_q;
        end

        always_comb begin
            unique case (src_i)
                SRC_VIDEO:   sel_o[ch] = vid_i[ch];
                SRC_BLANK:   sel_o[ch] = set.blank;
                SRC_SYNC_LO: sel_o[ch] = set.sync_lo;
                SRC_SYNC_HI: sel_o[ch] = set.sync_hi;
                default:     sel_o[ch] = set.blank;
            endcase
        end
    end

    // R11
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(frame_end_i)) |-> ($stable(luma_q) && $stable(chroma_q)));

endmodule

// File: rtl/vlm_headroom.sv
module vlm_headroom
    import vlm_pkg::*;
#(
    parameter int unsigned HEADROOM = 300
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_rgb,
    input  trio_t sel_i,
    output trio_t dac_o
);

    localparam code_t OFS      = code_t'(HEADROOM);
    localparam code_t CODE_TOP = {CODE_W{1'b1}};

    trio_t sum;
    trio_t dac_q;
    logic [NUM_CH-1:0] add_en;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        if (ch == 0) begin : g_always
            assign add_en[ch] = 1'b1;
        end else begin : g_rgb_only
            assign add_en[ch] = cfg_rgb;
        end
        assign sum[ch] = add_en[ch] ? sat_add(sel_i[ch], OFS) : sel_i[ch];
    end

    always_ff @(posedge clk) begin
        if (rst) dac_q <= '0;
        else     dac_q <= sum;
    end

    assign dac_o = dac_q;

    // R10
    sat_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (sum[1] >= sel_i[1]) && (sum[2] >= sel_i[2]) && (sum[0] >= sel_i[0]));

    // R10
    luma_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(sel_i[0]) <= (CODE_TOP - OFS)))
        |-> (dac_q[0] == $past(sel_i[0]) + OFS));

endmodule

// File: rtl/vid_level_mux.sv
module vid_level_mux
    import vlm_pkg::*;
#(
    parameter int unsigned PIX_W    = 12,
    parameter int unsigned LINE_W   = 11,
    parameter int unsigned HEADROOM = 300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_pc_mode,
    input  logic              cfg_rgb,
    input  logic              cfg_passthru,
    input  logic [PIX_W-1:0]  cfg_line_len,
    input  logic [PIX_W-1:0]  cfg_sync_w,
    input  logic [PIX_W-1:0]  cfg_act_start,
    input  logic [PIX_W-1:0]  cfg_act_end,
    input  logic [LINE_W-1:0] cfg_frame_lines,
    input  logic [LINE_W-1:0] cfg_field_lines,
    input  logic [LINE_W-1:0] cfg_vs_lines,
    input  logic [LINE_W-1:0] cfg_f1_first,
    input  logic [LINE_W-1:0] cfg_f1_last,
    input  logic [LINE_W-1:0] cfg_f2_first,
    input  logic [LINE_W-1:0] cfg_f2_last,
    input  logic [10:0]       cfg_y_blank,
    input  logic [10:0]       cfg_y_sync_lo,
    input  logic [10:0]       cfg_y_sync_hi,
    input  logic [10:0]       cfg_c_blank,
    input  logic [10:0]       cfg_c_sync_lo,
    input  logic [10:0]       cfg_c_sync_hi,
    input  logic [10:0]       vid_y,
    input  logic [10:0]       vid_cb,
    input  logic [10:0]       vid_cr,
    output logic [10:0]       dac_y,
    output logic [10:0]       dac_cb,
    output logic [10:0]       dac_cr,
    output logic              dac_field
);

    rast_t    rast;
    src_e     src;
    lvl_set_t luma_cfg;
    lvl_set_t chroma_cfg;
    trio_t    vid;
    trio_t    sel;
    trio_t    dac;
    logic     field_q;

    assign luma_cfg   = '{blank: cfg_y_blank, sync_lo: cfg_y_sync_lo, sync_hi: cfg_y_sync_hi};
    assign chroma_cfg = '{blank: cfg_c_blank, sync_lo: cfg_c_sync_lo, sync_hi: cfg_c_sync_hi};
    assign vid        = {vid_cr, vid_cb, vid_y};
    assign src        = pick_src(cfg_pc_mode, cfg_passthru, rast);

    vlm_raster #(.PIX_W(PIX_W), .LINE_W(LINE_W)) i_raster (
        .clk             (clk),
        .rst             (rst),
        .cfg_line_len    (cfg_line_len),
        .cfg_sync_w      (cfg_sync_w),
        .cfg_act_start   (cfg_act_start),
        .cfg_act_end     (cfg_act_end),
        .cfg_frame_lines (cfg_frame_lines),
        .cfg_field_lines (cfg_field_lines),
        .cfg_vs_lines    (cfg_vs_lines),
        .cfg_f1_first    (cfg_f1_first),
        .cfg_f1_last     (cfg_f1_last),
        .cfg_f2_first    (cfg_f2_first),
        .cfg_f2_last     (cfg_f2_last),
        .rast_o          (rast)
    );

    vlm_level_sel i_level_sel (
        .clk         (clk),
        .rst         (rst),
        .frame_end_i (rast.frame_end),
        .cfg_luma    (luma_cfg),
        .cfg_chroma  (chroma_cfg),
        .src_i       (src),
        .vid_i       (vid),
        .sel_o       (sel)
    );

    vlm_headroom #(.HEADROOM(HEADROOM)) i_headroom (
        .clk     (clk),
        .rst     (rst),
        .cfg_rgb (cfg_rgb),
        .sel_i   (sel),
        .dac_o   (dac)
    );

    always_ff @(posedge clk) begin
        if (rst) field_q <= 1'b0;
        else     field_q <= rast.field2;
    end

    assign dac_y     = dac[0];
    assign dac_cb    = dac[1];
    assign dac_cr    = dac[2];
    assign dac_field = field_q;

    // R8
    pc_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_pc_mode) && !$past(cfg_rgb))
        |-> ((dac_cb == $past(vid_cb)) && (dac_cr == $past(vid_cr))));

    // R6
    vsync_no_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_pc_mode && (rast.kind == LK_VSYNC)) |-> (src != SRC_VIDEO));

endmodule

// File: tb/test_vid_level_mux.sv
module test_vid_level_mux;

    localparam int PW = 12;
    localparam int LW = 11;
    localparam int HR = 300;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic c_pc = 0, c_rgb = 0, c_pass = 0;
    logic [PW-1:0] c_len = 20, c_sw = 2, c_as = 6, c_ae = 16;
    logic [LW-1:0] c_frame = 9, c_field = 5, c_vs = 1;
    logic [LW-1:0] c_f1a = 3, c_f1b = 4, c_f2a = 8, c_f2b = 9;
    logic [10:0] c_yb = 200, c_yl = 40, c_yh = 600;
    logic [10:0] c_cb = 512, c_cl = 100, c_ch = 900;
    logic [10:0] v_y = 0, v_cb = 0, v_cr = 0;
    logic [10:0] d_y, d_cb, d_cr;
    logic        d_field;

    int n_chk = 0;
    int n_err = 0;
    int m_line = 1, m_pix = 0, cyc = 0, pat = 0;
    int sh_y[3];
    int sh_c[3];

    vid_level_mux #(.PIX_W(PW), .LINE_W(LW), .HEADROOM(HR)) i_vid_level_mux (
        .clk(clk), .rst(rst),
        .cfg_pc_mode(c_pc), .cfg_rgb(c_rgb), .cfg_passthru(c_pass),
        .cfg_line_len(c_len), .cfg_sync_w(c_sw),
        .cfg_act_start(c_as), .cfg_act_end(c_ae),
        .cfg_frame_lines(c_frame), .cfg_field_lines(c_field), .cfg_vs_lines(c_vs),
        .cfg_f1_first(c_f1a), .cfg_f1_last(c_f1b),
        .cfg_f2_first(c_f2a), .cfg_f2_last(c_f2b),
        .cfg_y_blank(c_yb), .cfg_y_sync_lo(c_yl), .cfg_y_sync_hi(c_yh),
        .cfg_c_blank(c_cb), .cfg_c_sync_lo(c_cl), .cfg_c_sync_hi(c_ch),
        .vid_y(v_y), .vid_cb(v_cb), .vid_cr(v_cr),
        .dac_y(d_y), .dac_cb(d_cb), .dac_cr(d_cr), .dac_field(d_field)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load_shadow();
        sh_y = '{int'(c_yb), int'(c_yl), int'(c_yh)};
        sh_c = '{int'(c_cb), int'(c_cl), int'(c_ch)};
    endtask

    // Expected code per requirement; rule names the requirement applied.
    function automatic int model_code(input int ch, input int line, input int pix,
                                      input int v, output string rule);
        int lv[3];
        int code;
        bit fld2, vs, act;
        if (ch == 0) lv = sh_y; else lv = sh_c;
        fld2 = line > int'(c_field);
        vs   = fld2 ? (line <= int'(c_field) + int'(c_vs)) : (line <= int'(c_vs));
        act  = fld2 ? (line >= int'(c_f2a) && line <= int'(c_f2b))
                    : (line >= int'(c_f1a) && line <= int'(c_f1b));
        if (c_pc) begin code = v; rule = "R8"; end
        else if (pix < int'(c_sw)) begin code = lv[1]; rule = "R3"; end
        else if (pix < 2 * int'(c_sw)) begin code = lv[2]; rule = "R3"; end
        else if (vs) begin code = lv[1]; rule = "R6"; end
        else if (pix >= int'(c_as) && pix < int'(c_ae)) begin
            if (act) begin code = v; rule = "R4"; end
            else if (c_pass) begin code = v; rule = "R5"; end
            else begin code = lv[0]; rule = "R5"; end
        end else begin code = lv[0]; rule = "R7"; end
        if (ch == 0 || c_rgb) begin
            code = code + HR;
            if (code > 2047) code = 2047;
            rule = {rule, "/R10"};
        end
        if (ch != 0 && !c_pc) rule = {rule, "/R9"};
        return code;
    endfunction

    task automatic step(input string scen);
        int e[3];
        string r[3];
        int vv[3];
        int ef;
        if (pat == 0) begin
            vv[0] = (cyc * 37 + 5) % 2048;
            vv[1] = (cyc * 53 + 300) % 2048;
            vv[2] = (cyc * 71 + 1000) % 2048;
        end else begin
            vv[0] = 2000; vv[1] = 1800; vv[2] = 2047;
        end
        v_y = 11'(vv[0]); v_cb = 11'(vv[1]); v_cr = 11'(vv[2]);
        for (int ch = 0; ch < 3; ch++) e[ch] = model_code(ch, m_line, m_pix, vv[ch], r[ch]);
        ef = (m_line > int'(c_field)) ? 1 : 0;
        @(posedge clk);
        if (m_pix == int'(c_len) - 1 && m_line == int'(c_frame)) load_shadow();
        if (m_pix == int'(c_len) - 1) begin
            m_pix = 0;
            m_line = (m_line == int'(c_frame)) ? 1 : m_line + 1;
        end else m_pix++;
        cyc++;
        @(negedge clk);
        check({scen, " ", r[0], " ch0"}, d_y, e[0]);
        check({scen, " ", r[1], " ch1"}, d_cb, e[1]);
        check({scen, " ", r[2], " ch2"}, d_cr, e[2]);
        check({scen, " R2 field"}, d_field, ef);
    endtask

    task automatic run(input string scen, input int n);
        for (int i = 0; i < n; i++) step(scen);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        v_y = 11'd1234; v_cb = 11'd999; v_cr = 11'd77;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset y", d_y, 0);
        check("R1 reset cb", d_cb, 0);
        check("R1 reset cr", d_cr, 0);
        check("R1 reset field", d_field, 0);
        rst = 1'b0;
        m_line = 1; m_pix = 0;
        load_shadow();
    endtask

    // R2 R3 R4 R5 R6 R7 R9: YPbPr, two full frames
    task automatic t_ypbpr();
        c_pc = 0; c_rgb = 0; c_pass = 0; pat = 0;
        run("ypbpr", 360);
    endtask

    // R5: pass-through on blanking lines only
    task automatic t_passthru();
        c_pass = 1;
        run("passthru R5", 180);
        c_pass = 0;
    endtask

    // R10: offset on all channels
    task automatic t_rgb();
        c_rgb = 1;
        run("rgb R10", 180);
        c_rgb = 0;
    endtask

    // R8: PC-graphics mode forwards input everywhere
    task automatic t_pc();
        c_pc = 1;
        run("pc R8", 180);
        c_pc = 0;
    endtask

    // R10: saturation at 2047 with near-full-scale inputs
    task automatic t_saturate();
        c_rgb = 1; pat = 1;
        run("sat R10", 180);
        c_rgb = 0; pat = 0;
    endtask

    // R11: level codes changed mid-frame take effect at next frame
    task automatic t_level_update();
        while (m_line != 4) step("update R11");
        c_yb = 150; c_yl = 10; c_yh = 700; c_cb = 480; c_cl = 60; c_ch = 1100;
        run("update R11", 360);
    endtask

    initial begin
        #(50000 * 10);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1 actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_ypbpr();
        t_passthru();
        t_rgb();
        t_pc();
        t_saturate();
        t_level_update();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule